// File: doc/BRIEF.md
# Startup-Gated Window/Timeout Watchdog

This block supervises a host processor once the host has been powered up or woken. A startup trigger opens a configuration phase with a fixed deadline. Before that deadline the host must write the watchdog configuration register. The write chooses window or timeout operation and one of four periods. From then on the block expects the host to clear the watchdog by writing the same register, at a rate the chosen period sets. A missed clear produces a reset request. In window operation, a clear that arrives too early also produces one. Every reset request lasts a fixed number of milliseconds. After it the block returns to the configuration phase.

All timing is counted on a one-cycle millisecond tick enable. The design is one enumerated state machine with four named states:
- `ST_OFF` waits for the startup trigger.
- `ST_CFG` waits for the configuration write and runs the deadline.
- `ST_RUN` enforces the watchdog.
- `ST_RST` holds the reset request.

The transitions between them are:
- OFF→CFG on the startup trigger (*start*).
- CFG→CFG when the trigger comes again, which restarts the deadline (*restart*).
- CFG→RUN on a write (*configure*).
- CFG→RST when the deadline expires (*deadline miss*).
- RUN→RUN on an accepted clear (*kick*).
- RUN→RST on a clear in the closed half (*early kick*).
- RUN→RST when the period expires (*expiry*).
- RUN→CFG on the startup trigger (*wake*).
- RST→CFG when the reset time has elapsed (*release*).

Top module: `wdg_supervisor`

## Requirements
- R1: After `rst_n` is released, `mode` is 00 (idle), `rst_req` is 0 and `win_open` is 0. A write while idle has no effect, and `mode` stays 00.
- R2: A `start` pulse while idle gives `mode` 01 (configuration request). If 350 ticks then elapse with no write, `mode` becomes 11 and `rst_req` becomes 1 on the 350th tick.
- R3: A write in configuration request gives `mode` 10 (running). The write latches `wr_data[2]` as the timeout select (0 = window, 1 = timeout) and `wr_data[1:0]` as the period code (00 = 5, 01 = 45, 10 = 100, 11 = 350 ticks).
- R4: While running with no write, `mode` becomes 11 on the P-th tick after the last configuration write or accepted clear, where P is the selected period.
- R5: In window operation `win_open` is 0 until floor(P/2) ticks have passed since the last restart, and 1 from then on. A write while `win_open` is 0 gives `mode` 11.
- R6: An accepted clear restarts the period count from zero. In timeout operation `win_open` is 1 throughout, and any write before expiry is accepted.
- R7: The reset request lasts exactly 2 ticks, after which `mode` becomes 01. Writes and `start` pulses during the reset request are ignored.
- R8: A clear write while running does not change the latched timeout select or period.
- R9: A `start` pulse in configuration request or while running gives `mode` 01 with a fresh 350-tick deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle millisecond tick enable |
| start | input | 1 | Startup / wake-up trigger pulse |
| wr_en | input | 1 | Watchdog register write strobe |
| wr_data | input | 3 | Write data: [2] timeout select, [1:0] period code |
| rst_req | output | 1 | Reset request to the host |
| mode | output | 2 | Current state: 00 idle, 01 config request, 10 running, 11 reset |
| win_open | output | 1 | 1 when a clear would be accepted while running |

## Verification
Some rules are checked on every cycle by the assertions:
- A write during the closed half always leads to the reset state on the next cycle.
- Entry to running always follows a write made in configuration request.
- The count while running never reaches the selected period.
- The end of a reset request always lands in configuration request.

Other properties need the bench's scenarios to show them:
- the exact tick on which the deadline, the period and the reset time expire;
- the position of the window boundary for each period code;
- that clear writes leave the configuration untouched;
- that triggers and writes are ignored while idle or in reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        ST_OFF = 2'b00,
        ST_CFG = 2'b01,
        ST_RUN = 2'b10,
        ST_RST = 2'b11
    } wdg_state_e;

    localparam int CFG_W      = 3;
    localparam int CODE_W     = 2;
    localparam int NUM_CODES  = 1 << CODE_W;
    localparam int TMO_BIT    = 2;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdg_ms_counter.sv
module wdg_ms_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (cnt != {W{1'b1}})) else $error("counter wrap"); // R4

endmodule

// File: rtl/wdg_cfg_reg.sv
module wdg_cfg_reg
    import wdg_pkg::*;
#(
    parameter int W      = 9,
    parameter int PER_C0 = 5,
    parameter int PER_C1 = 45,
    parameter int PER_C2 = 100,
    parameter int PER_C3 = 350
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] din,
    output logic             tmo_sel,
    output logic [W-1:0]     period,
    output logic [W-1:0]     half
);

    localparam int PER_TAB [NUM_CODES] = '{PER_C0, PER_C1, PER_C2, PER_C3};

    logic [CODE_W-1:0] code_q;
    logic [W-1:0]      per_arr  [NUM_CODES];
    logic [W-1:0]      half_arr [NUM_CODES];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CODES; gi++) begin : g_tab
            assign per_arr[gi]  = W'(PER_TAB[gi]);
            assign half_arr[gi] = W'(PER_TAB[gi] / 2);
        end
    endgenerate

    // Reset value: window operation, longest period.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_sel <= 1'b0;
            code_q  <= {CODE_W{1'b1}};
        end else if (load) begin
            tmo_sel <= din[TMO_BIT];
            code_q  <= din[CODE_W-1:0];
        end
    end

    assign period = per_arr[code_q];
    assign half   = half_arr[code_q];

endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
    import wdg_pkg::*;
#(
    parameter int CFG_DEADLINE = 350,
    parameter int RST_DUR      = 2,
    parameter int PER_C0       = 5,
    parameter int PER_C1       = 45,
    parameter int PER_C2       = 100,
    parameter int PER_C3       = 350
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic             start,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic             rst_req,
    output logic [1:0]       mode,
    output logic             win_open
);

    localparam int MAXV  = max2(max2(max2(PER_C0, PER_C1), max2(PER_C2, PER_C3)),
                                max2(CFG_DEADLINE, RST_DUR));
    localparam int CNT_W = $clog2(MAXV + 1) + 1;

    wdg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period, half;
    logic             tmo_sel;
    logic             cnt_clr, cnt_inc, cfg_load;
    logic             closed, dl_hit, per_hit, rd_hit;

    wdg_ms_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    wdg_cfg_reg #(
        .W      (CNT_W),
        .PER_C0 (PER_C0),
        .PER_C1 (PER_C1),
        .PER_C2 (PER_C2),
        .PER_C3 (PER_C3)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .din     (wr_data),
        .tmo_sel (tmo_sel),
        .period  (period),
        .half    (half)
    );

    assign closed  = !tmo_sel && (cnt < half);
    assign dl_hit  = tick_ms && (cnt == CNT_W'(CFG_DEADLINE - 1));
    assign per_hit = tick_ms && (cnt == period - 1'b1);
    assign rd_hit  = tick_ms && (cnt == CNT_W'(RST_DUR - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and counter control
    always_comb begin
        state_d  = state_q;
        cnt_clr  = 1'b0;
        cnt_inc  = tick_ms;
        cfg_load = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                cnt_inc = 1'b0;
                if (start) begin
                    state_d = ST_CFG;
                    cnt_clr = 1'b1;
                end
            end
            ST_CFG: begin
                if (start) begin
                    cnt_clr = 1'b1;
                end else if (wr_en) begin
                    cfg_load = 1'b1;
                    state_d  = ST_RUN;
                    cnt_clr  = 1'b1;
                end else if (dl_hit) begin
                    state_d = ST_RST;
                    cnt_clr = 1'b1;
                end
            end
            ST_RUN: begin
                if (start) begin
                    state_d = ST_CFG;
                    cnt_clr = 1'b1;
                end else if (wr_en) begin
                    cnt_clr = 1'b1;
                    if (closed) begin
                        state_d = ST_RST;
                    end
                end else if (per_hit) begin
                    state_d = ST_RST;
                    cnt_clr = 1'b1;
                end
            end
            ST_RST: begin
                if (rd_hit) begin
                    state_d = ST_CFG;
                    cnt_clr = 1'b1;
                end
            end
            default: begin
                state_d = ST_OFF;
                cnt_clr = 1'b1;
            end
        endcase
    end

    // Outputs
    always_comb begin
        mode     = state_q;
        rst_req  = (state_q == ST_RST);
        win_open = (state_q == ST_RUN) && !closed;
    end

    AST_EARLY_KICK_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !start && wr_en && !win_open) |=> (mode == ST_RST)) else $error("early kick"); // R5

    AST_RUN_AFTER_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode == ST_RUN) |-> $past(wr_en && mode == ST_CFG)) else $error("bad run entry"); // R3

    AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt < period)) else $error("period overrun"); // R4

    AST_RELEASE_TO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> (mode == ST_CFG)) else $error("bad release"); // R7

endmodule

// File: tb/tb_wdg_supervisor.sv
module tb_wdg_supervisor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       start = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_data = 3'b000;
    logic       rst_req;
    logic [1:0] mode;
    logic       win_open;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdg_supervisor dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_ms  (tick_ms),
        .start    (start),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rst_req  (rst_req),
        .mode     (mode),
        .win_open (win_open)
    );

    // {timeout, code[1:0], delay[8:0], expect_fault}
    localparam int NV = 12;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 2'b01, 9'd10,  1'b1},
        {1'b0, 2'b01, 9'd21,  1'b1},
        {1'b0, 2'b01, 9'd22,  1'b0},
        {1'b0, 2'b00, 9'd1,   1'b1},
        {1'b0, 2'b00, 9'd2,   1'b0},
        {1'b0, 2'b00, 9'd4,   1'b0},
        {1'b1, 2'b00, 9'd0,   1'b0},
        {1'b1, 2'b00, 9'd4,   1'b0},
        {1'b0, 2'b10, 9'd49,  1'b1},
        {1'b0, 2'b10, 9'd50,  1'b0},
        {1'b1, 2'b11, 9'd3,   1'b0},
        {1'b0, 2'b11, 9'd174, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_ms = 1'b1;
            @(negedge clk) tick_ms = 1'b0;
        end
    endtask

    task automatic wr(input logic [2:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic to_cfg();
        if (mode == 2'b11) ticks(2);
        pulse_start();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state and ignored write
        chk("R1 mode", mode, 0);
        chk("R1 rst_req", rst_req, 0);
        chk("R1 win_open", win_open, 0);
        rst_n = 1'b1;
        @(negedge clk);
        wr(3'b000);
        ticks(3);
        chk("R1 write ignored", mode, 0);

        // R2: deadline
        pulse_start();
        chk("R2 cfg mode", mode, 1);
        ticks(349);
        chk("R2 before deadline", mode, 1);
        ticks(1);
        chk("R2 deadline miss", mode, 3);
        chk("R2 rst_req", rst_req, 1);

        // R7: reset duration, ignored inputs
        wr(3'b000);
        pulse_start();
        ticks(1);
        chk("R7 still reset", mode, 3);
        ticks(1);
        chk("R7 release", mode, 1);
        chk("R7 rst_req low", rst_req, 0);

        // R9: restart of deadline
        ticks(300);
        pulse_start();
        ticks(300);
        chk("R9 deadline restarted", mode, 1);
        ticks(50);
        chk("R9 new deadline miss", mode, 3);

        // R3 / R5 / R6: vector table
        for (int v = 0; v < NV; v++) begin
            logic       tmo;
            logic [1:0] code;
            int         dly;
            logic       flt;
            {tmo, code, dly, flt} = {VEC[v][12], VEC[v][11:10], int'(VEC[v][9:1]), VEC[v][0]};
            to_cfg();
            wr({tmo, code});
            chk("R3 run entry", mode, 2);
            ticks(dly);
            wr({tmo, code});
            chk(flt ? "R5 early clear" : "R6 accepted clear", mode, flt ? 3 : 2);
        end

        // R4: timeout expiry, period code 00
        to_cfg();
        wr(3'b100);
        ticks(4);
        chk("R4 before expiry", mode, 2);
        chk("R6 timeout win_open", win_open, 1);
        ticks(1);
        chk("R4 expiry", mode, 3);

        // R5: window boundary, code 01 (half 22)
        to_cfg();
        wr(3'b001);
        ticks(21);
        chk("R5 closed", win_open, 0);
        ticks(1);
        chk("R5 open", win_open, 1);
        ticks(22);
        chk("R4 code01 before expiry", mode, 2);
        ticks(1);
        chk("R4 code01 expiry", mode, 3);

        // R6: accepted clear restarts count, window code 00
        to_cfg();
        wr(3'b000);
        ticks(3);
        wr(3'b000);
        chk("R6 clear accepted", mode, 2);
        ticks(4);
        chk("R6 restarted", mode, 2);
        ticks(1);
        chk("R6 expiry after restart", mode, 3);

        // R8: clear write does not change config
        to_cfg();
        wr(3'b100);
        ticks(2);
        wr(3'b011);
        ticks(4);
        chk("R8 period kept", mode, 2);
        ticks(1);
        chk("R8 expiry at old period", mode, 3);

        // R9: start while running
        to_cfg();
        wr(3'b111);
        ticks(5);
        pulse_start();
        chk("R9 wake to cfg", mode, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule